// File: doc/BRIEF.md
# Biquinary Counting Digit Adder

This block adds one decimal digit column where each digit is held as a seven-wire biquinary code. The code has a two-wire range part, which picks the lower half (0 to 4) or the upper half (5 to 9), and a five-wire quinary part, which gives the position inside that half. The block never uses a binary adder. The range wires of the second operand are applied in one step by swapping the accumulator's range wires. The quinary position of the second operand is then added by rotating a one-hot ring, one place per clock. A carry in from a lower column adds one extra rotation. A ring wrap from the top position back to zero swaps the range, and a swap out of the upper half produces the decimal carry out.

A caller presents both operands and a carry in, then pulses `start`. While the block is working it raises `busy` and ignores any further `start`. It pulses `done` once the sum is ready. Both operands are checked against the one-hot-per-field rule when `start` is taken. If either operand is malformed, the block flags a code error and finishes at once without adding. The result wires are also checked at all times, and a bad result drives the same flag.

Top module: `bq_digit_adder`

## Requirements
- R1: A digit of value v is coded with range bit 1 high for v of 5 to 9 and range bit 0 high for v of 0 to 4, and quinary bit k high where k = v mod 5. Example: 7 is range 10 with quinary 00100.
- R2: While reset is held, and until the first accepted start, the sum reads as digit 0 (range 01, quinary 00001), and busy, done, carry_out and code_err are all low.
- R3: If start is taken while an operand has a range or quinary field with other than exactly one bit set, then on the next cycle code_err and done are high and busy stays low. In that case carry_out is 0 and the sum wires are left unchanged. This catches every single-bit flip of a valid operand.
- R4: A start taken with two valid operands raises busy and clears code_err on the next cycle.
- R5: When done pulses after a valid start, the sum wires carry (a + b + carry_in) mod 10 coded as in R1, and carry_out is 1 exactly when a + b + carry_in is 10 or more.
- R6: Counting the edge that takes start as the first edge, done is high right after edge number 2 + q + c. Here q is the quinary position of operand b and c is carry_in, so the worst case is 7 edges.
- R7: done is high for exactly one cycle, and busy falls on the same edge at which done rises.
- R8: A start seen while busy is high has no effect on the running addition or its result.
- R9: Whenever busy is low, the sum wires form a valid code with one bit set in each field, and code_err reflects only the operand check.
- R10: A carry_in of 1 adds one to the result and adds one cycle to the latency of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an addition (taken only while idle) |
| a_range | input | 2 | Operand A range field |
| a_quin | input | 5 | Operand A quinary field |
| b_range | input | 2 | Operand B range field |
| b_quin | input | 5 | Operand B quinary field |
| carry_in | input | 1 | Carry from the lower digit column |
| busy | output | 1 | Addition in progress |
| done | output | 1 | One-cycle completion pulse |
| sum_range | output | 2 | Result range field |
| sum_quin | output | 5 | Result quinary field |
| carry_out | output | 1 | Decimal carry to the next column |
| code_err | output | 1 | Operand or result failed the code check |

## Verification
Results arrive on three time scales. A malformed operand gives done and code_err one cycle after the start edge. A valid start raises busy one cycle later. The sum and carry become valid at the completion edge, 2 + q + c edges after start. The bench reference model keeps its own countdown of these edges from the operand values. It compares busy and done on every falling edge, and it compares sum, carry_out and code_err only while the model is idle, so intermediate ring positions are never judged.

// File: rtl/bq_pkg.sv
package bq_pkg;
  localparam int RANGE_W = 2;
  localparam int QUIN_W_DEF = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RANGE = 2'd1,
    ST_STEP  = 2'd2
  } add_state_e;
endpackage

// File: rtl/bq_code_check.sv
// Checks one biquinary digit: each field must hold exactly one set bit.
module bq_code_check #(
  parameter int RW = 2,
  parameter int QW = 5
) (
  input  logic [RW-1:0] rng,
  input  logic [QW-1:0] quin,
  output logic          ok
);
  localparam int CW = $clog2(QW + 1);

  logic [CW-1:0] rng_cnt;
  logic [CW-1:0] quin_cnt;

  always_comb begin
    rng_cnt = '0;
    for (int i = 0; i < RW; i++) begin
      rng_cnt = rng_cnt + CW'(rng[i]);
    end
  end

  always_comb begin
    quin_cnt = '0;
    for (int i = 0; i < QW; i++) begin
      quin_cnt = quin_cnt + CW'(quin[i]);
    end
  end

  assign ok = (rng_cnt == CW'(1)) && (quin_cnt == CW'(1));
endmodule

// File: rtl/bq_ring_step.sv
// One counting increment: rotate the quinary ring, and swap the range on wrap.
module bq_ring_step #(
  parameter int QW = 5
) (
  input  logic [1:0]    rng_in,
  input  logic [QW-1:0] quin_in,
  output logic [1:0]    rng_out,
  output logic [QW-1:0] quin_out,
  output logic          dec_carry
);
  logic wrap;

  assign wrap      = quin_in[QW-1];
  assign quin_out  = {quin_in[QW-2:0], quin_in[QW-1]};
  assign rng_out   = wrap ? {rng_in[0], rng_in[1]} : rng_in;
  assign dec_carry = wrap & rng_in[1];
endmodule

// File: rtl/bq_offset_enc.sv
// Turns a one-hot quinary field into its step count.
module bq_offset_enc #(
  parameter int QW = 5,
  parameter int CW = $clog2(QW + 1)
) (
  input  logic [QW-1:0] quin,
  output logic [CW-1:0] offset
);
  always_comb begin
    offset = '0;
    for (int i = 0; i < QW; i++) begin
      if (quin[i]) offset = offset | CW'(i);
    end
  end
endmodule

// File: rtl/bq_digit_adder.sv
module bq_digit_adder #(
  parameter int QW = bq_pkg::QUIN_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    a_range,
  input  logic [QW-1:0] a_quin,
  input  logic [1:0]    b_range,
  input  logic [QW-1:0] b_quin,
  input  logic          carry_in,
  output logic          busy,
  output logic          done,
  output logic [1:0]    sum_range,
  output logic [QW-1:0] sum_quin,
  output logic          carry_out,
  output logic          code_err
);
  import bq_pkg::*;

  localparam int CW = $clog2(QW + 2);
  localparam int NCHK = 3;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // state registers and their next values
  add_state_e    state_q, state_d;
  logic [1:0]    acc_rng_q, acc_rng_d;
  logic [QW-1:0] acc_quin_q, acc_quin_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          bup_q, bup_d;
  logic          done_q, done_d;
  logic          carry_q, carry_d;
  logic          err_q, err_d;
  logic          acc_en;

  // code checks on operand a, operand b and the accumulator
  logic [1:0]    chk_rng  [NCHK];
  logic [QW-1:0] chk_quin [NCHK];
  logic [NCHK-1:0] chk_ok;

  assign chk_rng[0]  = a_range;
  assign chk_quin[0] = a_quin;
  assign chk_rng[1]  = b_range;
  assign chk_quin[1] = b_quin;
  assign chk_rng[2]  = acc_rng_q;
  assign chk_quin[2] = acc_quin_q;

  for (genvar g = 0; g < NCHK; g++) begin : g_chk
    bq_code_check #(.RW(RANGE_W), .QW(QW)) u_chk (
      .rng  (chk_rng[g]),
      .quin (chk_quin[g]),
      .ok   (chk_ok[g])
    );
  end

  logic operands_ok;
  assign operands_ok = chk_ok[0] & chk_ok[1];

  // step count of operand b
  logic [CW-1:0] b_off;
  bq_offset_enc #(.QW(QW), .CW(CW)) u_off (
    .quin   (b_quin),
    .offset (b_off)
  );

  // one ring increment of the accumulator
  logic [1:0]    step_rng;
  logic [QW-1:0] step_quin;
  logic          step_carry;
  bq_ring_step #(.QW(QW)) u_step (
    .rng_in    (acc_rng_q),
    .quin_in   (acc_quin_q),
    .rng_out   (step_rng),
    .quin_out  (step_quin),
    .dec_carry (step_carry)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    acc_rng_d  = acc_rng_q;
    acc_quin_d = acc_quin_q;
    cnt_d      = cnt_q;
    bup_d      = bup_q;
    carry_d    = carry_q;
    err_d      = err_q;
    done_d     = 1'b0;
    acc_en     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          carry_d = 1'b0;
          if (!operands_ok) begin
            err_d  = 1'b1;
            done_d = 1'b1;
          end else begin
            err_d      = 1'b0;
            acc_en     = 1'b1;
            acc_rng_d  = a_range;
            acc_quin_d = a_quin;
            cnt_d      = b_off + CW'(carry_in);
            bup_d      = b_range[1];
            state_d    = ST_RANGE;
          end
        end
      end
      ST_RANGE: begin
        if (bup_q) begin
          acc_en    = 1'b1;
          acc_rng_d = {acc_rng_q[0], acc_rng_q[1]};
          if (acc_rng_q[1]) carry_d = 1'b1;
        end
        if (cnt_q == '0) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_STEP;
        end
      end
      ST_STEP: begin
        acc_en     = 1'b1;
        acc_rng_d  = step_rng;
        acc_quin_d = step_quin;
        if (step_carry) carry_d = 1'b1;
        cnt_d = cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q    <= ST_IDLE;
      acc_rng_q  <= 2'b01;
      acc_quin_q <= {{(QW-1){1'b0}}, 1'b1};
      cnt_q      <= '0;
      bup_q      <= 1'b0;
      done_q     <= 1'b0;
      carry_q    <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bup_q   <= bup_d;
      done_q  <= done_d;
      carry_q <= carry_d;
      err_q   <= err_d;
      if (acc_en) begin
        acc_rng_q  <= acc_rng_d;
        acc_quin_q <= acc_quin_d;
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign sum_range = acc_rng_q;
  assign sum_quin  = acc_quin_q;
  assign carry_out = carry_q;
  assign code_err  = err_q | ~chk_ok[2];
endmodule

// File: rtl/bq_digit_adder_chk.sv
module bq_digit_adder_chk #(
  parameter int QW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    a_range,
  input logic [QW-1:0] a_quin,
  input logic [1:0]    b_range,
  input logic [QW-1:0] b_quin,
  input logic          busy,
  input logic          done,
  input logic [1:0]    sum_range,
  input logic [QW-1:0] sum_quin,
  input logic          code_err
);
  localparam int BW = $clog2(QW + 3);

  logic bad_op;
  assign bad_op = ($countones(a_range) != 1) || ($countones(a_quin) != 1) ||
                  ($countones(b_range) != 1) || ($countones(b_quin) != 1);

  // busy run length, counted here rather than with a long delay
  logic [BW-1:0] busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + BW'(1);
    else           busy_len <= '0;
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_ends_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_bad_operand_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && bad_op) |=> (code_err && done && !busy));

  p_good_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !bad_op) |=> (busy && !code_err));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  p_result_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (($countones(sum_range) == 1) && ($countones(sum_quin) == 1)));

  p_latency_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= BW'(QW + 1));
endmodule

bind bq_digit_adder bq_digit_adder_chk #(.QW(QW)) u_bq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .a_range   (a_range),
  .a_quin    (a_quin),
  .b_range   (b_range),
  .b_quin    (b_quin),
  .busy      (busy),
  .done      (done),
  .sum_range (sum_range),
  .sum_quin  (sum_quin),
  .code_err  (code_err)
);

// File: tb/bq_digit_adder_bench.sv
`timescale 1ns/1ps
module bq_digit_adder_bench;
  logic       clk;
  logic       rst_n;
  logic       start;
  logic [1:0] a_range, b_range;
  logic [4:0] a_quin, b_quin;
  logic       carry_in;
  logic       busy, done, carry_out, code_err;
  logic [1:0] sum_range;
  logic [4:0] sum_quin;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string phase = "R5";

  bq_digit_adder u_bq_digit_adder (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_range(a_range), .a_quin(a_quin),
    .b_range(b_range), .b_quin(b_quin),
    .carry_in(carry_in), .busy(busy), .done(done),
    .sum_range(sum_range), .sum_quin(sum_quin),
    .carry_out(carry_out), .code_err(code_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // R1 coding, written from the requirement
  function automatic logic [6:0] enc(int v);
    logic [1:0] r;
    logic [4:0] q;
    r = (v >= 5) ? 2'b10 : 2'b01;
    q = 5'b00001 << (v % 5);
    return {r, q};
  endfunction

  function automatic bit valid_code(logic [1:0] r, logic [4:0] q);
    return ($countones(r) == 1) && ($countones(q) == 1);
  endfunction

  function automatic int qpos(logic [4:0] q);
    for (int k = 0; k < 5; k++) if (q[k]) return k;
    return 0;
  endfunction

  function automatic int dval(logic [1:0] r, logic [4:0] q);
    return (r[1] ? 5 : 0) + qpos(q);
  endfunction

  // reference model, stepped on every rising edge
  bit   m_busy, m_done, m_cout, m_err;
  int   m_cnt, m_sum, m_pending;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cout = 0; m_err = 0;
      m_cnt = 0; m_sum = 0; m_pending = 0;
    end else begin
      m_done = 0;
      if (!m_busy && start) begin
        m_cout = 0;
        if (!valid_code(a_range, a_quin) || !valid_code(b_range, b_quin)) begin
          m_err = 1;
          m_done = 1;
        end else begin
          m_err = 0;
          m_busy = 1;
          m_cnt = 1 + qpos(b_quin) + int'(carry_in);
          m_pending = dval(a_range, a_quin) + dval(b_range, b_quin) + int'(carry_in);
        end
      end else if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0;
          m_done = 1;
          m_sum  = m_pending % 10;
          m_cout = (m_pending >= 10);
        end
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // comparison on every falling edge
  always @(negedge clk) begin
    if (rst_n && cyc > 3) begin
      check(busy == m_busy, {"R6 ", phase}, "busy", busy, m_busy);
      check(done == m_done, {"R7 ", phase}, "done", done, m_done);
      if (!m_busy) begin
        check({sum_range, sum_quin} == enc(m_sum), {"R1/R5 ", phase}, "sum code",
              int'({sum_range, sum_quin}), int'(enc(m_sum)));
        check(carry_out == m_cout, {"R5 ", phase}, "carry_out", carry_out, m_cout);
        check(code_err == m_err, {"R3/R9 ", phase}, "code_err", code_err, m_err);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R6 watchdog expired: actual %0d expected below %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(logic [6:0] a, logic [6:0] b, logic ci);
    @(negedge clk);
    {a_range, a_quin} = a;
    {b_range, b_quin} = b;
    carry_in = ci;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; carry_in = 1'b0;
    a_range = 2'b01; a_quin = 5'b00001; b_range = 2'b01; b_quin = 5'b00001;
    repeat (3) @(negedge clk);
    // R2: reset state
    check({sum_range, sum_quin} == 7'b01_00001, "R2", "sum at reset",
          int'({sum_range, sum_quin}), int'(7'b01_00001));
    check({busy, done, carry_out, code_err} == 4'b0, "R2", "flags at reset",
          int'({busy, done, carry_out, code_err}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check({sum_range, sum_quin} == 7'b01_00001, "R2", "sum after release",
          int'({sum_range, sum_quin}), int'(7'b01_00001));

    // R1: 7 + 0 gives range 10 quinary 00100
    phase = "R1";
    run(7'b10_00100, 7'b01_00001, 1'b0);
    check({sum_range, sum_quin} == 7'b10_00100, "R1", "digit seven",
          int'({sum_range, sum_quin}), int'(7'b10_00100));

    // R5 and R6: every operand pair, carry in 0 then 1 (R10)
    for (int ci = 0; ci < 2; ci++) begin
      phase = (ci == 0) ? "R5" : "R10";
      for (int a = 0; a < 10; a++)
        for (int b = 0; b < 10; b++)
          run(enc(a), enc(b), ci[0]);
    end

    // R3: every single-bit flip of a valid operand, on each side
    for (int bit_i = 0; bit_i < 7; bit_i++) begin
      phase = "R3";
      run(enc(3) ^ (7'b1 << bit_i), enc(4), 1'b0);
      run(enc(6), enc(8) ^ (7'b1 << bit_i), 1'b1);
    end
    // R3: double-set range field, empty quinary
    run(7'b11_00010, enc(2), 1'b0);
    run(enc(5), 7'b10_00000, 1'b0);

    // R4: valid start after an error clears code_err
    phase = "R4";
    run(enc(9), enc(9), 1'b1);
    check({sum_range, sum_quin} == enc(9) && carry_out, "R4", "19 after error",
          int'({sum_range, sum_quin}), int'(enc(9)));

    // R8: start pulses during a long addition are ignored
    phase = "R8";
    @(negedge clk);
    {a_range, a_quin} = enc(8); {b_range, b_quin} = enc(9); carry_in = 1'b1;
    start = 1'b1;
    @(negedge clk);
    {a_range, a_quin} = 7'b11_11111; {b_range, b_quin} = enc(1); carry_in = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
    check({sum_range, sum_quin} == enc(8), "R8", "sum of 8+9+1",
          int'({sum_range, sum_quin}), int'(enc(8)));
    check(carry_out == 1'b1 && code_err == 1'b0, "R8", "carry/err after 8+9+1",
          int'({carry_out, code_err}), 2);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule